// File: doc/BRIEF.md
# Exception Priority Controller

This block holds the state of a fixed set of exception vectors. Each vector has an enable bit, a pending bit, an active bit and a priority. Vectors 0 to 15 are internal exceptions. Vectors from 16 upward are external interrupt lines, and each of them also keeps a sampled level. The three lowest vectors are the reset, non-maskable and hard-fault exceptions. Their priorities are fixed at -3, -2 and -1, and they are always enabled. Every other vector has a programmable priority. Only the upper `IMPL_BITS` bits of that priority are stored.

The controller continuously picks the most urgent exception that is both pending and enabled, and reports that exception's group priority. A grouping field splits each priority into a group part, used for preemption, and a subpriority part. The execution priority is the smallest group priority among the active vectors, or 256 when no vector is active. An exception request goes to the core when the selected pending exception's group is strictly more urgent than the execution priority. The core takes the winner with an acknowledge, which moves it from pending to active and records it as the exception being handled. The core ends a handler with a complete request, which clears the active bit and returns a status code one cycle later.

Top module: `excp_prio_ctrl`

## Requirements
- R1: After reset nothing is pending or active, `pend_valid` and `exc_req` are 0, `exec_prio` reads 256, programmable priorities read 0 and the grouping field is 0.
- R2: A priority write keeps only the top `IMPL_BITS` bits of `cfg_wdata` (0xFF reads back as 224 with 8-bit priorities and 3 implemented bits). Writes to vectors 0, 1 and 2 are ignored, and those vectors read -3, -2 and -1 on `rd_prio`.
- R3: The `cfg_sel` codes are 0 for enable (bit 0 of `cfg_wdata`), 1 for priority and 2 for grouping. A pending vector whose enable bit is 0 is never selected. Vectors 0 to 2 are always enabled.
- R4: Among pending and enabled vectors, the lowest full priority wins, which orders by group and then by subpriority. On an equal priority the lower vector number wins. `pend_grp` gives the winner's group priority.
- R5: With grouping value g, the group priority of a programmable vector is its priority with bits g down to 0 cleared.
- R6: `exec_prio` is the minimum group priority over all active vectors, and 256 when none is active.
- R7: `exc_req` is 1 exactly when `pend_valid` is 1 and `pend_grp` is strictly less than `exec_prio`.
- R8: `ack_req` with a valid winner clears the winner's pending bit, sets its active bit and loads `cur_exc` with its number at the next edge. `ack_req` with nothing pending changes nothing.
- R9: `cmpl_req` clears the named vector's active bit. One cycle later `cmpl_valid` pulses with `cmpl_status` set to 2'b11 (-1) if the vector was not active, 2'b01 if no other vector stays active, and 2'b00 if another vector stays active.
- R10: When a set-pending and an acknowledge hit the same vector in one cycle, the vector ends up both active and pending.
- R11: A rising edge on `irq_lvl[k]` marks vector 16+k pending. A line that stays high does not mark the vector pending again after it has been acknowledged.
- R12: `rd_ready` is 1 when vector `rd_vec` is enabled and its group priority is strictly below `exec_prio`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 enable, 1 priority, 2 grouping |
| cfg_vec | input | VEC_W | Vector addressed by the write |
| cfg_wdata | input | PRIO_W | Write data |
| set_pend | input | 1 | Mark `set_vec` pending |
| set_vec | input | VEC_W | Vector to mark pending |
| irq_lvl | input | NUM_VEC-16 | Level lines of the external vectors |
| ack_req | input | 1 | Take the current winner |
| cur_exc | output | VEC_W | Vector most recently acknowledged |
| cmpl_req | input | 1 | Complete vector `cmpl_vec` |
| cmpl_vec | input | VEC_W | Vector being completed |
| cmpl_valid | output | 1 | Completion status valid |
| cmpl_status | output | 2 | Completion code, signed 2-bit |
| pend_valid | output | 1 | A pending and enabled vector exists |
| pend_vec | output | VEC_W | Selected pending vector |
| pend_grp | output | PRIO_W+2 | Signed group priority of the winner |
| exec_prio | output | PRIO_W+2 | Signed execution priority |
| exc_req | output | 1 | Preemption request to the core |
| rd_vec | input | VEC_W | Vector for priority and readiness query |
| rd_prio | output | PRIO_W+2 | Signed effective priority of `rd_vec` |
| rd_ready | output | 1 | `rd_vec` could preempt now |

## Verification
Two functions can land in the same cycle: a set-pending and an acknowledge aimed at the same vector. The bench raises the hard-fault vector so that it becomes the winner, then drives `ack_req` and `set_pend` for that vector on one edge. It judges the result from the ports. `exec_prio` must drop to -1, which shows the vector is active. `pend_vec` must still name it while `exc_req` stays low, which shows it is still pending. A second acknowledge must then clear the pending bit, and selection must move on to the next vector.

// File: rtl/prio_ctrl_pkg.sv
package prio_ctrl_pkg;
  localparam int FIXED_CNT = 3;   // vectors with fixed negative priority
  localparam int INT_VEC   = 16;  // internal exception count

  typedef enum logic [1:0] {
    CFG_ENABLE = 2'd0,
    CFG_PRIO   = 2'd1,
    CFG_GROUP  = 2'd2
  } cfg_sel_e;

  typedef enum logic [1:0] {
    CST_REMAIN = 2'b00,
    CST_BASE   = 2'b01,
    CST_NACT   = 2'b11
  } cmpl_st_e;
endpackage

// File: rtl/epc_vec_bank.sv
module epc_vec_bank import prio_ctrl_pkg::*; #(
  parameter int NUM_VEC   = 32,
  parameter int PRIO_W    = 8,
  parameter int IMPL_BITS = 3,
  localparam int VEC_W    = $clog2(NUM_VEC),
  localparam int GRP_W    = $clog2(PRIO_W),
  localparam int NUM_EXT  = NUM_VEC - INT_VEC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [VEC_W-1:0]     cfg_vec,
  input  logic [PRIO_W-1:0]    cfg_wdata,
  input  logic                 set_vld,
  input  logic [VEC_W-1:0]     set_vec,
  input  logic [NUM_EXT-1:0]   irq_lvl,
  input  logic                 ack_fire,
  input  logic [VEC_W-1:0]     ack_vec,
  input  logic                 cmpl_fire,
  input  logic [VEC_W-1:0]     cmpl_vec,
  output logic [NUM_VEC-1:0]   en_o,
  output logic [NUM_VEC-1:0]   pend_o,
  output logic [NUM_VEC-1:0]   act_o,
  output logic [PRIO_W-1:0]    prio_o [NUM_VEC],
  output logic [GRP_W-1:0]     grp_sel_o
);
  localparam logic [PRIO_W-1:0] IMPL_MASK =
    PRIO_W'(((1 << IMPL_BITS) - 1) << (PRIO_W - IMPL_BITS));
  localparam logic [NUM_VEC-1:0] FIXED_EN =
    {{(NUM_VEC-FIXED_CNT){1'b0}}, {FIXED_CNT{1'b1}}};

  logic [NUM_VEC-1:0] en_q, en_d, pend_q, pend_d, act_q, act_d;
  logic [PRIO_W-1:0]  prio_q [NUM_VEC];
  logic [PRIO_W-1:0]  prio_d [NUM_VEC];
  logic [GRP_W-1:0]   grp_q, grp_d;
  logic [NUM_EXT-1:0] lvl_q;
  logic               cfg_prog;

  assign cfg_prog = int'(cfg_vec) >= FIXED_CNT;

  always_comb begin
    en_d   = en_q;
    pend_d = pend_q;
    act_d  = act_q;
    prio_d = prio_q;
    grp_d  = grp_q;
    if (cfg_we) begin
      unique case (cfg_sel_e'(cfg_sel))
        CFG_ENABLE: if (cfg_prog) en_d[cfg_vec] = cfg_wdata[0];
        CFG_PRIO:   if (cfg_prog) prio_d[cfg_vec] = cfg_wdata & IMPL_MASK;
        CFG_GROUP:  grp_d = cfg_wdata[GRP_W-1:0];
        default:    ;
      endcase
    end
    if (cmpl_fire) act_d[cmpl_vec] = 1'b0;
    if (ack_fire) begin
      pend_d[ack_vec] = 1'b0;
      act_d[ack_vec]  = 1'b1;
    end
    for (int k = 0; k < NUM_EXT; k++)
      if (irq_lvl[k] && !lvl_q[k]) pend_d[INT_VEC+k] = 1'b1;
    // a new pending event outranks the acknowledge clear
    if (set_vld) pend_d[set_vec] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= FIXED_EN;
      pend_q <= '0;
      act_q  <= '0;
      grp_q  <= '0;
      lvl_q  <= '0;
      for (int i = 0; i < NUM_VEC; i++) prio_q[i] <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      act_q  <= act_d;
      grp_q  <= grp_d;
      lvl_q  <= irq_lvl;
      for (int i = 0; i < NUM_VEC; i++) prio_q[i] <= prio_d[i];
    end
  end

  assign en_o      = en_q;
  assign pend_o    = pend_q;
  assign act_o     = act_q;
  assign prio_o    = prio_q;
  assign grp_sel_o = grp_q;
endmodule

// File: rtl/epc_prio_map.sv
module epc_prio_map import prio_ctrl_pkg::*; #(
  parameter int NUM_VEC = 32,
  parameter int PRIO_W  = 8,
  localparam int GRP_W  = $clog2(PRIO_W),
  localparam int SP_W   = PRIO_W + 2
) (
  input  logic [PRIO_W-1:0]      prio_i [NUM_VEC],
  input  logic [GRP_W-1:0]       grp_sel,
  output logic signed [SP_W-1:0] eff_prio [NUM_VEC],
  output logic signed [SP_W-1:0] eff_grp  [NUM_VEC]
);
  logic [PRIO_W-1:0] grp_mask;
  assign grp_mask = ~((PRIO_W'(2) << grp_sel) - PRIO_W'(1));

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    if (i < FIXED_CNT) begin : g_fixed
      localparam logic signed [SP_W-1:0] FIXV = SP_W'(i - FIXED_CNT);
      assign eff_prio[i] = FIXV;
      assign eff_grp[i]  = FIXV;
    end else begin : g_prog
      assign eff_prio[i] = {2'b00, prio_i[i]};
      assign eff_grp[i]  = {2'b00, prio_i[i] & grp_mask};
    end
  end
endmodule

// File: rtl/epc_pend_sel.sv
module epc_pend_sel #(
  parameter int NUM_VEC = 32,
  parameter int PRIO_W  = 8,
  localparam int VEC_W  = $clog2(NUM_VEC),
  localparam int SP_W   = PRIO_W + 2
) (
  input  logic [NUM_VEC-1:0]     pend,
  input  logic [NUM_VEC-1:0]     en,
  input  logic signed [SP_W-1:0] eff_prio [NUM_VEC],
  input  logic signed [SP_W-1:0] eff_grp  [NUM_VEC],
  output logic                   win_vld,
  output logic [VEC_W-1:0]       win_vec,
  output logic signed [SP_W-1:0] win_grp
);
  localparam logic signed [SP_W-1:0] IDLE_PRIO = SP_W'(2 ** PRIO_W);
  logic signed [SP_W-1:0] best;

  // strict compare keeps the lower vector number on a tie
  always_comb begin
    win_vld = 1'b0;
    win_vec = '0;
    best    = IDLE_PRIO;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (pend[i] && en[i] && (!win_vld || eff_prio[i] < best)) begin
        win_vld = 1'b1;
        win_vec = VEC_W'(i);
        best    = eff_prio[i];
      end
    end
    win_grp = win_vld ? eff_grp[win_vec] : IDLE_PRIO;
  end
endmodule

// File: rtl/epc_exec_calc.sv
module epc_exec_calc #(
  parameter int NUM_VEC = 32,
  parameter int PRIO_W  = 8,
  localparam int SP_W   = PRIO_W + 2
) (
  input  logic [NUM_VEC-1:0]     act,
  input  logic signed [SP_W-1:0] eff_grp [NUM_VEC],
  output logic signed [SP_W-1:0] exec_prio
);
  localparam logic signed [SP_W-1:0] IDLE_PRIO = SP_W'(2 ** PRIO_W);

  always_comb begin
    exec_prio = IDLE_PRIO;
    for (int i = 0; i < NUM_VEC; i++)
      if (act[i] && eff_grp[i] < exec_prio) exec_prio = eff_grp[i];
  end
endmodule

// File: rtl/excp_prio_ctrl.sv
module excp_prio_ctrl import prio_ctrl_pkg::*; #(
  parameter int NUM_VEC   = 32,
  parameter int PRIO_W    = 8,
  parameter int IMPL_BITS = 3,
  localparam int VEC_W    = $clog2(NUM_VEC),
  localparam int SP_W     = PRIO_W + 2,
  localparam int NUM_EXT  = NUM_VEC - INT_VEC
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [1:0]             cfg_sel,
  input  logic [VEC_W-1:0]       cfg_vec,
  input  logic [PRIO_W-1:0]      cfg_wdata,
  input  logic                   set_pend,
  input  logic [VEC_W-1:0]       set_vec,
  input  logic [NUM_EXT-1:0]     irq_lvl,
  input  logic                   ack_req,
  output logic [VEC_W-1:0]       cur_exc,
  input  logic                   cmpl_req,
  input  logic [VEC_W-1:0]       cmpl_vec,
  output logic                   cmpl_valid,
  output logic [1:0]             cmpl_status,
  output logic                   pend_valid,
  output logic [VEC_W-1:0]       pend_vec,
  output logic signed [SP_W-1:0] pend_grp,
  output logic signed [SP_W-1:0] exec_prio,
  output logic                   exc_req,
  input  logic [VEC_W-1:0]       rd_vec,
  output logic signed [SP_W-1:0] rd_prio,
  output logic                   rd_ready
);
  localparam int GRP_W = $clog2(PRIO_W);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  logic [NUM_VEC-1:0]     en_w, pend_w, act_w, rest_act;
  logic [PRIO_W-1:0]      prio_w [NUM_VEC];
  logic [GRP_W-1:0]       grp_sel_w;
  logic signed [SP_W-1:0] eff_prio [NUM_VEC];
  logic signed [SP_W-1:0] eff_grp  [NUM_VEC];
  logic                   ack_fire;
  logic                   cmpl_vld_q, cmpl_vld_d;
  cmpl_st_e               cmpl_st_q, cmpl_st_d;
  logic [VEC_W-1:0]       cur_q, cur_d;

  assign ack_fire = ack_req && pend_valid;

  epc_vec_bank #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W), .IMPL_BITS(IMPL_BITS)) u_bank (
    .clk(clk), .rst_n(rst_n_i),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_vec(cfg_vec), .cfg_wdata(cfg_wdata),
    .set_vld(set_pend), .set_vec(set_vec), .irq_lvl(irq_lvl),
    .ack_fire(ack_fire), .ack_vec(pend_vec),
    .cmpl_fire(cmpl_req), .cmpl_vec(cmpl_vec),
    .en_o(en_w), .pend_o(pend_w), .act_o(act_w), .prio_o(prio_w), .grp_sel_o(grp_sel_w)
  );

  epc_prio_map #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W)) u_map (
    .prio_i(prio_w), .grp_sel(grp_sel_w), .eff_prio(eff_prio), .eff_grp(eff_grp)
  );

  epc_pend_sel #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W)) u_sel (
    .pend(pend_w), .en(en_w), .eff_prio(eff_prio), .eff_grp(eff_grp),
    .win_vld(pend_valid), .win_vec(pend_vec), .win_grp(pend_grp)
  );

  epc_exec_calc #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W)) u_exec (
    .act(act_w), .eff_grp(eff_grp), .exec_prio(exec_prio)
  );

  assign rest_act = act_w & ~(NUM_VEC'(1) << cmpl_vec);

  always_comb begin
    cmpl_vld_d = cmpl_req;
    cmpl_st_d  = cmpl_st_q;
    if (cmpl_req) begin
      if (!act_w[cmpl_vec])    cmpl_st_d = CST_NACT;
      else if (|rest_act)      cmpl_st_d = CST_REMAIN;
      else                     cmpl_st_d = CST_BASE;
    end
    cur_d = ack_fire ? pend_vec : cur_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cmpl_vld_q <= 1'b0;
      cmpl_st_q  <= CST_REMAIN;
      cur_q      <= '0;
    end else begin
      cmpl_vld_q <= cmpl_vld_d;
      if (cmpl_req) cmpl_st_q <= cmpl_st_d;
      if (ack_fire) cur_q     <= cur_d;
    end
  end

  assign cmpl_valid  = cmpl_vld_q;
  assign cmpl_status = cmpl_st_q;
  assign cur_exc     = cur_q;
  assign exc_req     = pend_valid && (pend_grp < exec_prio);
  assign rd_prio     = eff_prio[rd_vec];
  assign rd_ready    = en_w[rd_vec] && (eff_grp[rd_vec] < exec_prio);
endmodule

module epc_chk #(
  parameter int NUM_VEC = 32,
  parameter int SP_W    = 10,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ack_req,
  input logic                   cmpl_req,
  input logic [VEC_W-1:0]       cmpl_vec,
  input logic                   cmpl_valid,
  input logic                   pend_valid,
  input logic [VEC_W-1:0]       pend_vec,
  input logic                   exc_req,
  input logic signed [SP_W-1:0] exec_prio,
  input logic [VEC_W-1:0]       cur_exc,
  input logic [NUM_VEC-1:0]     act,
  input logic [NUM_VEC-1:0]     pend,
  input logic [NUM_VEC-1:0]     en
);
  a_r3_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (pend[pend_vec] && en[pend_vec]));
  a_r6_exec_range: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_prio >= -3) && (exec_prio <= 256));
  a_r6_idle_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |-> (exec_prio == 256));
  a_r7_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid |-> !exc_req);
  a_r8_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && pend_valid) |=> (act[$past(pend_vec)] && cur_exc == $past(pend_vec)));
  a_r9_cmpl_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_req |=> cmpl_valid);
  a_r9_cmpl_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_req && !(ack_req && pend_valid && pend_vec == cmpl_vec)) |=> !act[$past(cmpl_vec)]);
endmodule

bind excp_prio_ctrl epc_chk #(.NUM_VEC(NUM_VEC), .SP_W(SP_W)) u_chk (
  .clk(clk), .rst_n(rst_n_i), .ack_req(ack_req), .cmpl_req(cmpl_req),
  .cmpl_vec(cmpl_vec), .cmpl_valid(cmpl_valid), .pend_valid(pend_valid),
  .pend_vec(pend_vec), .exc_req(exc_req), .exec_prio(exec_prio),
  .cur_exc(cur_exc), .act(act_w), .pend(pend_w), .en(en_w)
);

// File: tb/sim_excp_prio_ctrl.sv
`timescale 1ns/1ps
module sim_excp_prio_ctrl;
  localparam int NUM_VEC = 32;
  localparam int PRIO_W  = 8;
  localparam int VEC_W   = $clog2(NUM_VEC);
  localparam int SP_W    = PRIO_W + 2;
  localparam int NUM_EXT = NUM_VEC - 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, set_pend, ack_req, cmpl_req;
  logic [1:0] cfg_sel;
  logic [VEC_W-1:0] cfg_vec, set_vec, cmpl_vec, rd_vec;
  logic [PRIO_W-1:0] cfg_wdata;
  logic [NUM_EXT-1:0] irq_lvl;
  logic [VEC_W-1:0] cur_exc, pend_vec;
  logic cmpl_valid, pend_valid, exc_req, rd_ready;
  logic [1:0] cmpl_status;
  logic signed [SP_W-1:0] pend_grp, exec_prio, rd_prio;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int    exp_q[$];
  string req_q[$];

  always #2.5 clk = ~clk;

  excp_prio_ctrl #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W), .IMPL_BITS(3)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_vec(cfg_vec),
    .cfg_wdata(cfg_wdata), .set_pend(set_pend), .set_vec(set_vec), .irq_lvl(irq_lvl),
    .ack_req(ack_req), .cur_exc(cur_exc), .cmpl_req(cmpl_req), .cmpl_vec(cmpl_vec),
    .cmpl_valid(cmpl_valid), .cmpl_status(cmpl_status), .pend_valid(pend_valid),
    .pend_vec(pend_vec), .pend_grp(pend_grp), .exec_prio(exec_prio), .exc_req(exc_req),
    .rd_vec(rd_vec), .rd_prio(rd_prio), .rd_ready(rd_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: completion results popped from the scoreboard
  always @(negedge clk) begin
    if (rst_n && cmpl_valid) begin
      if (exp_q.size() == 0) chk("R9 unexpected completion", 1, 0);
      else chk(req_q.pop_front(), int'(cmpl_status), exp_q.pop_front());
    end
  end

  task automatic do_cfg(input int sel, input int vec, input int data);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_vec = VEC_W'(vec); cfg_wdata = PRIO_W'(data);
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic do_pend(input int vec);
    set_pend = 1; set_vec = VEC_W'(vec);
    @(negedge clk); set_pend = 0;
  endtask
  task automatic do_ack();
    ack_req = 1; @(negedge clk); ack_req = 0;
  endtask
  task automatic do_cmpl(input int vec, input int exp, input string req);
    exp_q.push_back(exp); req_q.push_back(req);
    cmpl_req = 1; cmpl_vec = VEC_W'(vec);
    @(negedge clk); cmpl_req = 0;
  endtask
  task automatic rd(input int vec);
    rd_vec = VEC_W'(vec); #1;
  endtask

  initial begin
    #500000;
    if (!done) begin
      chk("watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; set_pend = 0; ack_req = 0; cmpl_req = 0;
    cfg_sel = 0; cfg_vec = 0; cfg_wdata = 0; set_vec = 0; cmpl_vec = 0;
    rd_vec = 0; irq_lvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 pend_valid", pend_valid, 0);
    chk("R1 exec_prio", exec_prio, 256);
    chk("R1 exc_req", exc_req, 0);
    rd(5);  chk("R1 prio reset", rd_prio, 0);
    rd(0);  chk("R2 fixed reset prio", rd_prio, -3);
    rd(2);  chk("R2 fixed hardfault prio", rd_prio, -1);

    // R2 masking and protected vectors
    do_cfg(1, 0, 8'h40);  rd(0);  chk("R2 fixed write ignored", rd_prio, -3);
    do_cfg(1, 20, 8'hFF); rd(20); chk("R2 low bits masked", rd_prio, 224);

    // R3 disabled vector not selected
    do_pend(20);
    chk("R3 disabled not pending", pend_valid, 0);
    do_cfg(0, 20, 1);
    chk("R3 enabled selected", pend_vec, 20);
    chk("R4 group of winner", pend_grp, 224);
    chk("R7 request when idle", exc_req, 1);

    // R4 tie on priority: lower number wins
    do_cfg(1, 17, 8'h60); do_cfg(1, 18, 8'h60);
    do_cfg(0, 17, 1);     do_cfg(0, 18, 1);
    do_pend(18); do_pend(17);
    chk("R4 tie lower vector", pend_vec, 17);
    chk("R4 tie group", pend_grp, 96);

    // R5 grouping 5 clears bits 5..0; subpriority breaks group tie
    do_cfg(2, 0, 5);
    do_cfg(1, 19, 8'h40); do_cfg(0, 19, 1); do_pend(19);
    chk("R4 subpriority winner", pend_vec, 19);
    chk("R5 group masked", pend_grp, 64);

    // R8 acknowledge
    do_ack();
    chk("R8 cur_exc", cur_exc, 19);
    chk("R6 exec from active", exec_prio, 64);
    chk("R8 next winner", pend_vec, 17);
    chk("R7 equal group no request", exc_req, 0);
    rd(17); chk("R12 equal group not ready", rd_ready, 0);
    rd(2);  chk("R12 hardfault ready", rd_ready, 1);

    // R10 set-pending and acknowledge collide on vector 2
    do_pend(2);
    chk("R4 negative prio wins", pend_vec, 2);
    chk("R7 preempt request", exc_req, 1);
    set_pend = 1; set_vec = 2; ack_req = 1;
    @(negedge clk); set_pend = 0; ack_req = 0;
    chk("R10 now active", exec_prio, -1);
    chk("R10 still pending", pend_vec, 2);
    chk("R10 valid", pend_valid, 1);
    chk("R7 no request equal", exc_req, 0);
    do_ack();
    chk("R10 second ack clears", pend_vec, 17);

    // R9 completion codes
    do_cmpl(5, 3, "R9 not active");
    do_cmpl(2, 0, "R9 another remains");
    chk("R6 exec after complete", exec_prio, 64);
    do_cmpl(19, 1, "R9 back to base");
    chk("R6 idle exec", exec_prio, 256);
    chk("R7 request again", exc_req, 1);

    // R8 acknowledge with nothing pending
    do_ack(); do_ack(); do_ack();
    chk("R8 drained", pend_valid, 0);
    chk("R8 last cur", cur_exc, 20);
    do_ack();
    chk("R8 empty ack ignored cur", cur_exc, 20);
    chk("R8 empty ack ignored exec", exec_prio, 64);

    // R11 level lines
    do_cfg(0, 21, 1);
    irq_lvl[5] = 1; @(negedge clk);
    chk("R11 rising edge pends", pend_vec, 21);
    chk("R7 urgent external", exc_req, 1);
    do_ack();
    repeat (3) @(negedge clk);
    chk("R11 held high no repend", pend_valid, 0);
    irq_lvl[5] = 0; @(negedge clk);
    irq_lvl[5] = 1; @(negedge clk);
    chk("R11 second edge pends", pend_vec, 21);
    do_cmpl(21, 0, "R9 others active");
    @(negedge clk);

    if (exp_q.size() != 0) chk("R9 missing completions", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule